// File: doc/BRIEF.md
# Reconfigurable Array Datapath Tile

This block is one compute tile for a coarse-grained reconfigurable array. Four neighbouring tiles feed it data over the north, east, south and west inputs, and it drives a single data output toward its neighbours. Inside it, two operand selectors feed an arithmetic/logic unit. A result selector chooses the value that goes to the tile's one result register, and an output selector chooses whether the neighbours see that value at once or the registered copy.

Every selector and the ALU operation are fixed by a static 13-bit configuration word. The word is written through a parallel port while the array is idle and then stays constant while the array runs. The register's output also feeds back into both operand selectors, so a single tile can accumulate, or can serve as a one-cycle delay element on a routing path.

Top module: `cgra_tile`

## Requirements
- R1: A synchronous reset clears both the configuration word and the result register, so `data_out` reads zero with any input values.
- R2: Operand selector codes (fields `sel_a` at cfg bits [8:6] and `sel_b` at [5:3]) pick these sources: 0 north, 1 east, 2 south, 3 west, 4 the result register. Codes 5, 6 and 7 give zero.
- R3: ALU opcodes (cfg bits [12:9]) give results modulo 2^WIDTH: 1 add (A+B), 2 subtract (A-B), 5 AND, 6 OR, 7 XOR.
- R4: Opcode 3 gives the low WIDTH bits of A*B. Opcode 4 gives the unsigned quotient A/B, or all ones when B is zero.
- R5: Opcode 8 shifts A left and opcode 9 shifts A right logically. In both cases the shift amount is only the low log2(WIDTH) bits of B.
- R6: The result select field (cfg bits [2:1]) picks the value sent to the register: 0 the ALU result, 1 operand A, 2 operand B, 3 zero.
- R7: When `en` is high, the result register loads the selected value on each rising edge. When `en` is low, it holds its value.
- R8: The output select bit (cfg bit 0) drives `data_out` from the selected value when it is 0, with no delay, or from the result register when it is 1.
- R9: The configuration word is loaded from `cfg_data` on a rising edge where `cfg_we` is high, and takes effect after that edge. While `cfg_we` is low, changes on `cfg_data` have no effect.
- R10: Opcode 0 and the unused opcodes 10 to 15 make the ALU produce zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Array run enable for the result register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 13 | Configuration word: opcode, two operand selects, result select, output select |
| in_n | input | WIDTH | Data from the north neighbour (source code 0) |
| in_e | input | WIDTH | Data from the east neighbour (source code 1) |
| in_s | input | WIDTH | Data from the south neighbour (source code 2) |
| in_w | input | WIDTH | Data from the west neighbour (source code 3) |
| data_out | output | WIDTH | Tile output to neighbours |

## Verification
The tile holds two pieces of state: the configuration word and the result register. A bad configuration bit shows at `data_out` on the first negative clock edge after the write, because the output path from the selectors is combinational. A result register that loads while `en` is low, or misses a load while `en` is high, shows one cycle later, either when the output select points at the register or when the register is fed back as an operand. The accumulation run with feedback makes such an error grow on every cycle.

// File: rtl/cgra_tile_pkg.sv
package cgra_tile_pkg;

    localparam int CFG_W = 13;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_MUL = 4'd3,
        OP_DIV = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9
    } alu_op_e;

    typedef enum logic [2:0] {
        SRC_N    = 3'd0,
        SRC_E    = 3'd1,
        SRC_S    = 3'd2,
        SRC_W    = 3'd3,
        SRC_FB   = 3'd4,
        SRC_Z5   = 3'd5,
        SRC_Z6   = 3'd6,
        SRC_Z7   = 3'd7
    } src_sel_e;

    typedef enum logic [1:0] {
        RS_ALU  = 2'd0,
        RS_OPA  = 2'd1,
        RS_OPB  = 2'd2,
        RS_ZERO = 2'd3
    } res_sel_e;

    typedef enum logic {
        OS_COMB = 1'b0,
        OS_REG  = 1'b1
    } out_sel_e;

    typedef struct packed {
        alu_op_e  op;
        src_sel_e sel_a;
        src_sel_e sel_b;
        res_sel_e rsel;
        out_sel_e osel;
    } tile_cfg_t;

endpackage

// File: rtl/cgra_tile_cfg.sv
module cgra_tile_cfg
    import cgra_tile_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_data,
    output tile_cfg_t            cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= tile_cfg_t'(cfg_data);
        end
    end

    // R9: a strobe loads the word, no strobe keeps it
    p_cfg_load_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == tile_cfg_t'($past(cfg_data))));
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/cgra_tile_opmux.sv
module cgra_tile_opmux
    import cgra_tile_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] src_n,
    input  logic [WIDTH-1:0] src_e,
    input  logic [WIDTH-1:0] src_s,
    input  logic [WIDTH-1:0] src_w,
    input  logic [WIDTH-1:0] src_fb,
    input  src_sel_e         sel,
    output logic [WIDTH-1:0] opnd
);

    always_comb begin
        unique case (sel)
            SRC_N:   opnd = src_n;
            SRC_E:   opnd = src_e;
            SRC_S:   opnd = src_s;
            SRC_W:   opnd = src_w;
            SRC_FB:  opnd = src_fb;
            default: opnd = '0;
        endcase
    end

endmodule

// File: rtl/cgra_tile_alu.sv
module cgra_tile_alu
    import cgra_tile_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] y
);

    localparam int SHW = $clog2(WIDTH);

    logic [SHW-1:0]   shamt;
    logic [WIDTH-1:0] quot;

    assign shamt = opb[SHW-1:0];

    always_comb begin
        if (opb == '0) begin
            quot = '1;
        end else begin
            quot = opa / opb;
        end
    end

    always_comb begin
        unique case (op)
            OP_ADD:  y = opa + opb;
            OP_SUB:  y = opa - opb;
            OP_MUL:  y = opa * opb;
            OP_DIV:  y = quot;
            OP_AND:  y = opa & opb;
            OP_OR:   y = opa | opb;
            OP_XOR:  y = opa ^ opb;
            OP_SHL:  y = opa << shamt;
            OP_SHR:  y = opa >> shamt;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/cgra_tile.sv
module cgra_tile
    import cgra_tile_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic [WIDTH-1:0]     in_n,
    input  logic [WIDTH-1:0]     in_e,
    input  logic [WIDTH-1:0]     in_s,
    input  logic [WIDTH-1:0]     in_w,
    output logic [WIDTH-1:0]     data_out
);

    localparam int NOPND = 2;

    tile_cfg_t        cfg;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] opnd [NOPND];
    src_sel_e         osel_v [NOPND];
    logic [WIDTH-1:0] alu_y;
    logic [WIDTH-1:0] res_val;

    cgra_tile_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .cfg_q    (cfg)
    );

    assign osel_v[0] = cfg.sel_a;
    assign osel_v[1] = cfg.sel_b;

    for (genvar gi = 0; gi < NOPND; gi++) begin : g_opnd
        cgra_tile_opmux #(.WIDTH(WIDTH)) u_mux (
            .src_n  (in_n),
            .src_e  (in_e),
            .src_s  (in_s),
            .src_w  (in_w),
            .src_fb (acc_q),
            .sel    (osel_v[gi]),
            .opnd   (opnd[gi])
        );
    end

    cgra_tile_alu #(.WIDTH(WIDTH)) u_alu (
        .op  (cfg.op),
        .opa (opnd[0]),
        .opb (opnd[1]),
        .y   (alu_y)
    );

    always_comb begin
        unique case (cfg.rsel)
            RS_ALU:  res_val = alu_y;
            RS_OPA:  res_val = opnd[0];
            RS_OPB:  res_val = opnd[1];
            default: res_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= res_val;
        end
    end

    always_comb begin
        unique case (cfg.osel)
            OS_REG:  data_out = acc_q;
            default: data_out = res_val;
        endcase
    end

    // R7: register loads with enable, holds without
    p_acc_load_r7: assert property (@(posedge clk) disable iff (rst)
        en |=> (acc_q == $past(res_val)));
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q));
    // R2: unused operand codes feed zero
    p_zero_opa_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg.sel_a > SRC_FB) |-> (opnd[0] == '0));
    // R4: divide by zero saturates
    p_divzero_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.op == OP_DIV && opnd[1] == '0) |-> (alu_y == '1));
    // R8: registered output path
    p_out_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.osel == OS_REG) |-> (data_out == acc_q));
    // R10: unused opcodes produce zero
    p_nop_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg.op > OP_SHR || cfg.op == OP_NOP) |-> (alu_y == '0));

endmodule

// File: tb/cgra_tile_tb.sv
module cgra_tile_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         en;
    logic         cfg_we;
    logic [12:0]  cfg_data;
    logic [W-1:0] in_n, in_e, in_s, in_w;
    logic [W-1:0] data_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    cgra_tile #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w), .data_out(data_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [12:0] mk(input int op, input int sa, input int sb,
                                      input int rs, input int os);
        return {op[3:0], sa[2:0], sb[2:0], rs[1:0], os[0]};
    endfunction

    function automatic logic [W-1:0] model(input int op, input int a, input int b);
        int r;
        case (op)
            1: r = a + b;
            2: r = a - b;
            3: r = a * b;
            4: r = (b == 0) ? 255 : a / b;
            5: r = a & b;
            6: r = a | b;
            7: r = a ^ b;
            8: r = a << (b % 8);
            9: r = a >> (b % 8);
            default: r = 0;
        endcase
        return r[W-1:0];
    endfunction

    task automatic set_cfg(input logic [12:0] w);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_data = w;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; cfg_we = 1'b0; cfg_data = '0;
        in_n = 8'h11; in_e = 8'h22; in_s = 8'h33; in_w = 8'h44;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset output", data_out, 8'h00);

        // R3 R4 R5 R10: sweep every opcode, A from north, B from east
        for (int op = 0; op < 16; op++) begin
            set_cfg(mk(op, 0, 1, 0, 0));
            for (int a = 0; a < 256; a += 7) begin
                for (int b = 0; b < 256; b += 5) begin
                    @(negedge clk);
                    in_n = a[W-1:0];
                    in_e = b[W-1:0];
                    #1;
                    if (op >= 1 && op <= 2 || op >= 5 && op <= 7)
                        chk("R3 alu op", data_out, model(op, a, b));
                    else if (op == 3 || op == 4)
                        chk("R4 mul/div", data_out, model(op, a, b));
                    else if (op == 8 || op == 9)
                        chk("R5 shift", data_out, model(op, a, b));
                    else
                        chk("R10 nop/unused", data_out, model(op, a, b));
                end
            end
        end

        // R7 R2: load the register with 0x5A, then select it as operand
        in_n = 8'h5A; in_e = 8'h22; in_s = 8'h33; in_w = 8'h44;
        set_cfg(mk(1, 0, 5, 0, 0));
        @(negedge clk); en = 1'b1;
        @(negedge clk); en = 1'b0;
        for (int s = 0; s < 8; s++) begin
            logic [W-1:0] e;
            set_cfg(mk(1, s, 7, 0, 0));
            #1;
            case (s)
                0: e = 8'h5A;
                1: e = 8'h22;
                2: e = 8'h33;
                3: e = 8'h44;
                4: e = 8'h5A;
                default: e = 8'h00;
            endcase
            chk("R2 operand A select", data_out, e);
            set_cfg(mk(1, 7, s, 0, 0));
            #1;
            chk("R2 operand B select", data_out, e);
        end

        // R6: result select with A=east(0x22), B=south(0x33), op SUB
        set_cfg(mk(2, 1, 2, 0, 0)); #1; chk("R6 rsel alu", data_out, 8'hEF);
        set_cfg(mk(2, 1, 2, 1, 0)); #1; chk("R6 rsel opA", data_out, 8'h22);
        set_cfg(mk(2, 1, 2, 2, 0)); #1; chk("R6 rsel opB", data_out, 8'h33);
        set_cfg(mk(2, 1, 2, 3, 0)); #1; chk("R6 rsel zero", data_out, 8'h00);

        // R7 R8: accumulate north=3 into the register, registered output
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset after run", data_out, 8'h00);
        in_n = 8'd3;
        set_cfg(mk(1, 4, 0, 0, 1));
        en = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R7 accumulate", data_out, 8'(3 * i));
        end
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_n = 8'(i + 90);
            #1;
            chk("R7 hold without enable", data_out, 8'd15);
            chk("R8 registered output ignores inputs", data_out, 8'd15);
        end

        // R8: combinational path follows inputs at once
        set_cfg(mk(1, 4, 0, 0, 0));
        in_n = 8'd10; #1;
        chk("R8 comb output", data_out, 8'd25);

        // R9: cfg_data ignored without strobe
        @(negedge clk);
        cfg_data = mk(0, 5, 5, 3, 0);
        @(negedge clk);
        @(negedge clk);
        chk("R9 no strobe no change", data_out, 8'd25);
        set_cfg(mk(0, 5, 5, 3, 0)); #1;
        chk("R9 strobe loads word", data_out, 8'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule